// File: doc/BRIEF.md
# Controller SCL Waveform Generator

This block builds the serial clock for the controller side of a two-wire power-management bus. It advances only on a prescaled state-machine tick. The period and the high time come either from programmed offset fields or from built-in defaults for standard (100 kHz) and fast (400 kHz) operation, where the tick runs at 10 MHz or slower. The clock output is an open-drain pull-low. After each release the generator waits until it samples the line high before it counts the high phase, so a target can stretch the clock.

A data engine beside the block uses it. The engine asserts a run request to keep the clock going. It takes one strobe in the middle of each low phase to change SDA and one strobe in the middle of each high phase to sample SDA. Before a start edge, whether the bus is leaving idle or making a repeated start, the generator holds SCL released. It raises setup-done once enough ticks have passed since the last rising edge, and the engine then drops SDA. Byte sequencing, arbitration and SDA driving belong to the engine.

Top module: `scl_waveform_gen`

## Requirements
- R1: With `overrideEn`=1, one full SCL cycle (low phase plus high phase) lasts `cfgPeriod`+4 ticks whenever `cfgPeriod`+1 > `cfgHigh`.
- R2: With `overrideEn`=1, the released (high) phase lasts `cfgHigh`+3 ticks and the low phase lasts `cfgPeriod`−`cfgHigh`+1 ticks.
- R3: After a release, the high-phase count starts only at the first tick that samples `sclIn` high. Each extra tick in which a target holds the line low lengthens the released time by one tick, and `sdaSampleStb` fires only while `sclIn` is high.
- R4: `sdaChangeStb` pulses once per low phase, on the tick that ends low-phase tick number floor(low/2), counting from 0. `sdaSampleStb` pulses once per high phase, on the tick that ends high-phase tick number floor(high/2), where tick 0 is the one that first samples the line high.
- R5: When `rptStartReq` is high as a high phase ends, SCL stays released. `setupDone` rises max(`cfgSetup`, high) ticks after the rising edge and stays high with SCL released until `rptStartReq` falls.
- R6: When started from idle, SCL stays released and `setupDone` rises `cfgSetup` ticks after the first tick. When `setupDone` is high, `rptStartReq` is low and a tick arrives, the next cycle starts a low phase.
- R7: With `overrideEn`=0 the programmed fields are ignored. `fastMode`=0 gives a high time of 50 ticks and a low time of 50 ticks. `fastMode`=1 gives a high time of 12 ticks and a low time of 13 ticks.
- R8: One clock after `runReq` is low, SCL is released, `setupDone` is low and no strobe fires. All counters are held at zero while stopped.
- R9: No phase changes state in a clock cycle without `tickEn`. With one tick every N clocks, every phase length in clocks is N times its length in ticks.
- R10: When `cfgHigh` > `cfgPeriod` the low phase is clamped to one tick and the high phase keeps `cfgHigh`+3 ticks.
- R11: In reset SCL is released and every strobe and `setupDone` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Prescaled state-machine tick, one clock wide |
| runReq | input | 1 | Keep generating clocks; low stops and releases SCL |
| rptStartReq | input | 1 | Hold SCL released after the current high phase for a start edge |
| sclIn | input | 1 | Sampled level of the SCL line |
| overrideEn | input | 1 | 1 = use programmed fields, 0 = use built-in defaults |
| fastMode | input | 1 | Default set: 0 = standard, 1 = fast |
| cfgPeriod | input | 8 | Period offset; period = value + 4 ticks |
| cfgHigh | input | 8 | High-time offset; high = value + 3 ticks |
| cfgSetup | input | 8 | Minimum ticks from SCL rise to a start edge |
| sclPullLow | output | 1 | Open-drain drive: 1 pulls SCL low |
| sdaChangeStb | output | 1 | Mid-low strobe for SDA changes |
| sdaSampleStb | output | 1 | Mid-high strobe for SDA sampling |
| setupDone | output | 1 | Start setup time met with SCL released |

## Verification
A wrong phase counter shows up at the pull-low output within one SCL period as a low or high phase of the wrong length, or as a strobe at the wrong offset in its phase. A broken stretch handshake shows up as a high phase that is too short after the bench holds the line low. A setup counter that is not restarted at the rising edge makes `setupDone` rise too early or too late before the next low phase. A state left over after a stop shows up as a pulled-low SCL or a stray `setupDone` in the first clock after `runReq` falls.

// File: rtl/scl_gen_pkg.sv
`timescale 1ns/1ps
package scl_gen_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_WAITHI,
    ST_HIGH
  } sclState_t;

  // strobes from the control FSM to the counter datapath
  typedef struct packed {
    logic cntClr;
    logic cntOne;
    logic cntInc;
    logic setClr;
    logic setOne;
    logic setInc;
  } dpCmd_t;

  // compare results from the datapath back to the control FSM
  typedef struct packed {
    logic lowLast;
    logic lowMid;
    logic highLast;
    logic highMid;
    logic setupMet;
  } dpFlags_t;

endpackage

// File: rtl/scl_gen_dp.sv
`timescale 1ns/1ps
module scl_gen_dp
  import scl_gen_pkg::*;
#(
  parameter int FIELD_W         = 8,
  parameter int PERIOD_ADD      = 4,
  parameter int HIGH_ADD        = 3,
  parameter int DEF_STD_PERIOD  = 96,
  parameter int DEF_STD_HIGH    = 47,
  parameter int DEF_STD_SETUP   = 47,
  parameter int DEF_FAST_PERIOD = 21,
  parameter int DEF_FAST_HIGH   = 9,
  parameter int DEF_FAST_SETUP  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic               overrideEn,
  input  logic               fastMode,
  input  logic [FIELD_W-1:0] cfgPeriod,
  input  logic [FIELD_W-1:0] cfgHigh,
  input  logic [FIELD_W-1:0] cfgSetup,
  output dpFlags_t           flags
);

  localparam int CNT_W = FIELD_W + 2;
  localparam logic [FIELD_W-1:0] STD_P  = FIELD_W'(DEF_STD_PERIOD);
  localparam logic [FIELD_W-1:0] STD_H  = FIELD_W'(DEF_STD_HIGH);
  localparam logic [FIELD_W-1:0] STD_S  = FIELD_W'(DEF_STD_SETUP);
  localparam logic [FIELD_W-1:0] FAST_P = FIELD_W'(DEF_FAST_PERIOD);
  localparam logic [FIELD_W-1:0] FAST_H = FIELD_W'(DEF_FAST_HIGH);
  localparam logic [FIELD_W-1:0] FAST_S = FIELD_W'(DEF_FAST_SETUP);
  localparam logic [FIELD_W-1:0] SET_MAX = {FIELD_W{1'b1}};

  logic [FIELD_W-1:0] effPeriod, effHigh, effSetup;
  logic [CNT_W-1:0]   periodLen, highLen, lowLen;
  logic [CNT_W-1:0]   phaseCnt;
  logic [FIELD_W-1:0] setupCnt;

  // timing source: programmed fields or one of two default sets
  always_comb begin
    if (overrideEn) begin
      effPeriod = cfgPeriod;
      effHigh   = cfgHigh;
      effSetup  = cfgSetup;
    end else if (fastMode) begin
      effPeriod = FAST_P;
      effHigh   = FAST_H;
      effSetup  = FAST_S;
    end else begin
      effPeriod = STD_P;
      effHigh   = STD_H;
      effSetup  = STD_S;
    end
  end

  // phase lengths in ticks; low phase never shorter than one tick
  always_comb begin
    periodLen = CNT_W'(effPeriod) + CNT_W'(PERIOD_ADD);
    highLen   = CNT_W'(effHigh) + CNT_W'(HIGH_ADD);
    if (periodLen > highLen) lowLen = periodLen - highLen;
    else                     lowLen = CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (cmd.cntClr) begin
      phaseCnt <= '0;
    end else if (cmd.cntOne) begin
      phaseCnt <= CNT_W'(1);
    end else if (cmd.cntInc) begin
      phaseCnt <= phaseCnt + CNT_W'(1);
    end
  end

  // ticks since the last rising edge, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      setupCnt <= '0;
    end else if (cmd.setClr) begin
      setupCnt <= '0;
    end else if (cmd.setOne) begin
      setupCnt <= FIELD_W'(1);
    end else if (cmd.setInc && setupCnt != SET_MAX) begin
      setupCnt <= setupCnt + FIELD_W'(1);
    end
  end

  always_comb begin
    flags.lowLast  = (phaseCnt == lowLen - CNT_W'(1));
    flags.lowMid   = (phaseCnt == (lowLen >> 1));
    flags.highLast = (phaseCnt == highLen - CNT_W'(1));
    flags.highMid  = (phaseCnt == (highLen >> 1));
    flags.setupMet = (setupCnt >= effSetup);
  end

endmodule

// File: rtl/scl_gen_ctrl.sv
`timescale 1ns/1ps
module scl_gen_ctrl
  import scl_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickEn,
  input  logic     runReq,
  input  logic     rptStartReq,
  input  logic     sclIn,
  input  dpFlags_t flags,
  output dpCmd_t   cmd,
  output logic     sclPullLow,
  output logic     sdaChangeStb,
  output logic     sdaSampleStb,
  output logic     setupDone
);

  sclState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    cmd      = '0;
    if (!runReq) begin
      stateNxt   = ST_IDLE;
      cmd.cntClr = 1'b1;
      cmd.setClr = 1'b1;
    end else if (tickEn) begin
      unique case (state)
        ST_IDLE: begin
          stateNxt   = ST_SETUP;
          cmd.cntClr = 1'b1;
          cmd.setClr = 1'b1;
        end
        ST_SETUP: begin
          cmd.setInc = 1'b1;
          if (flags.setupMet && !rptStartReq) begin
            stateNxt   = ST_LOW;
            cmd.cntClr = 1'b1;
          end
        end
        ST_LOW: begin
          if (flags.lowLast) begin
            stateNxt   = ST_WAITHI;
            cmd.cntClr = 1'b1;
          end else begin
            cmd.cntInc = 1'b1;
          end
        end
        ST_WAITHI: begin
          if (sclIn) begin
            stateNxt   = ST_HIGH;
            cmd.cntOne = 1'b1;
            cmd.setOne = 1'b1;
          end
        end
        ST_HIGH: begin
          cmd.setInc = 1'b1;
          if (flags.highLast) begin
            stateNxt   = rptStartReq ? ST_SETUP : ST_LOW;
            cmd.cntClr = 1'b1;
          end else begin
            cmd.cntInc = 1'b1;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign sclPullLow   = (state == ST_LOW);
  assign sdaChangeStb = runReq && tickEn && (state == ST_LOW) && flags.lowMid;
  assign sdaSampleStb = runReq && tickEn && (state == ST_HIGH) && flags.highMid;
  assign setupDone    = runReq && (state == ST_SETUP) && flags.setupMet;

endmodule

// File: rtl/scl_waveform_gen.sv
`timescale 1ns/1ps
module scl_waveform_gen
  import scl_gen_pkg::*;
#(
  parameter int FIELD_W         = 8,
  parameter int DEF_STD_PERIOD  = 96,
  parameter int DEF_STD_HIGH    = 47,
  parameter int DEF_STD_SETUP   = 47,
  parameter int DEF_FAST_PERIOD = 21,
  parameter int DEF_FAST_HIGH   = 9,
  parameter int DEF_FAST_SETUP  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  logic               runReq,
  input  logic               rptStartReq,
  input  logic               sclIn,
  input  logic               overrideEn,
  input  logic               fastMode,
  input  logic [FIELD_W-1:0] cfgPeriod,
  input  logic [FIELD_W-1:0] cfgHigh,
  input  logic [FIELD_W-1:0] cfgSetup,
  output logic               sclPullLow,
  output logic               sdaChangeStb,
  output logic               sdaSampleStb,
  output logic               setupDone
);

  dpCmd_t   dpCmd;
  dpFlags_t dpFlags;

  scl_gen_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .tickEn       (tickEn),
    .runReq       (runReq),
    .rptStartReq  (rptStartReq),
    .sclIn        (sclIn),
    .flags        (dpFlags),
    .cmd          (dpCmd),
    .sclPullLow   (sclPullLow),
    .sdaChangeStb (sdaChangeStb),
    .sdaSampleStb (sdaSampleStb),
    .setupDone    (setupDone)
  );

  scl_gen_dp #(
    .FIELD_W         (FIELD_W),
    .PERIOD_ADD      (4),
    .HIGH_ADD        (3),
    .DEF_STD_PERIOD  (DEF_STD_PERIOD),
    .DEF_STD_HIGH    (DEF_STD_HIGH),
    .DEF_STD_SETUP   (DEF_STD_SETUP),
    .DEF_FAST_PERIOD (DEF_FAST_PERIOD),
    .DEF_FAST_HIGH   (DEF_FAST_HIGH),
    .DEF_FAST_SETUP  (DEF_FAST_SETUP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (dpCmd),
    .overrideEn (overrideEn),
    .fastMode   (fastMode),
    .cfgPeriod  (cfgPeriod),
    .cfgHigh    (cfgHigh),
    .cfgSetup   (cfgSetup),
    .flags      (dpFlags)
  );

endmodule

// File: rtl/scl_waveform_gen_chk.sv
`timescale 1ns/1ps
module scl_waveform_gen_chk (
  input logic clk,
  input logic rstN,
  input logic tickEn,
  input logic runReq,
  input logic rptStartReq,
  input logic sclIn,
  input logic sclPullLow,
  input logic sdaSampleStb,
  input logic setupDone
);

  // R8: a stop releases the line and drops setup-done by the next clock
  p_release_on_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    !runReq |=> (!sclPullLow && !setupDone));

  // R9: without a tick the drive level cannot change while running
  p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(runReq) && !$past(tickEn)) |-> $stable(sclPullLow));

  // R3: sampling strobe only while the line is observed high
  p_sample_line_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    sdaSampleStb |-> sclIn);

  // R6: setup met, no repeated-start hold and a tick -> low phase begins
  p_start_after_setup_r6: assert property (@(posedge clk) disable iff (!rstN)
    (setupDone && !rptStartReq && tickEn && runReq) |=> sclPullLow);

endmodule

bind scl_waveform_gen scl_waveform_gen_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .tickEn       (tickEn),
  .runReq       (runReq),
  .rptStartReq  (rptStartReq),
  .sclIn        (sclIn),
  .sclPullLow   (sclPullLow),
  .sdaSampleStb (sdaSampleStb),
  .setupDone    (setupDone)
);

// File: tb/scl_waveform_gen_bench.sv
`timescale 1ns/1ps
module scl_waveform_gen_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic runReq = 1'b0;
  logic rptStartReq = 1'b0;
  logic overrideEn = 1'b1;
  logic fastMode = 1'b0;
  logic [7:0] cfgPeriod = 8'd20;
  logic [7:0] cfgHigh = 8'd4;
  logic [7:0] cfgSetup = 8'd2;
  logic sclPullLow, sdaChangeStb, sdaSampleStb, setupDone;
  logic stretchHold = 1'b0;
  logic sclIn;
  logic tickHalt = 1'b0;
  int   tickDiv = 1;
  int   tickPhase = 0;
  int   nChecks = 0;
  int   nFails = 0;

  assign sclIn = ~sclPullLow & ~stretchHold;

  always #2.5 clk = ~clk;

  scl_waveform_gen u_scl_waveform_gen (
    .clk          (clk),
    .rstN         (rstN),
    .tickEn       (tickEn),
    .runReq       (runReq),
    .rptStartReq  (rptStartReq),
    .sclIn        (sclIn),
    .overrideEn   (overrideEn),
    .fastMode     (fastMode),
    .cfgPeriod    (cfgPeriod),
    .cfgHigh      (cfgHigh),
    .cfgSetup     (cfgSetup),
    .sclPullLow   (sclPullLow),
    .sdaChangeStb (sdaChangeStb),
    .sdaSampleStb (sdaSampleStb),
    .setupDone    (setupDone)
  );

  typedef struct packed {
    logic       ovr;
    logic       fast;
    logic [7:0] fp;
    logic [7:0] fh;
    logic [3:0] div;
    logic [3:0] hold;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 8'd96, 8'd47, 4'd1, 4'd0},
    '{1'b1, 1'b0, 8'd10, 8'd2,  4'd1, 4'd0},
    '{1'b1, 1'b0, 8'd10, 8'd2,  4'd3, 4'd0},
    '{1'b1, 1'b0, 8'd6,  8'd6,  4'd1, 4'd0},
    '{1'b1, 1'b0, 8'd3,  8'd9,  4'd2, 4'd0},
    '{1'b0, 1'b0, 8'd5,  8'd1,  4'd1, 4'd0},
    '{1'b0, 1'b1, 8'd5,  8'd1,  4'd2, 4'd0},
    '{1'b1, 1'b0, 8'd20, 8'd4,  4'd1, 4'd5}
  };

  // tick source, updated just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (tickHalt) begin
        tickEn = 1'b0;
      end else begin
        tickEn = (tickPhase == 0);
        tickPhase = (tickPhase + 1 >= tickDiv) ? 0 : tickPhase + 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one full low phase followed by the released phase, sampled at negedges
  task automatic measure(input int holdS, output int lowC, output int highC,
                         output int chgOff, output int smpOff);
    lowC = 0; highC = 0; chgOff = -1; smpOff = -1;
    @(negedge clk);
    while (sclPullLow) @(negedge clk);
    while (!sclPullLow) @(negedge clk);
    stretchHold = (holdS > 0);
    while (sclPullLow) begin
      if (sdaChangeStb) chgOff = lowC;
      lowC++;
      @(negedge clk);
    end
    while (!sclPullLow) begin
      if (sdaSampleStb) smpOff = highC;
      if (holdS > 0 && highC == holdS - 1) stretchHold = 1'b0;
      highC++;
      @(negedge clk);
    end
    stretchHold = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk);
    runReq = 1'b0;
    rptStartReq = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int lowC, highC, chgOff, smpOff, n, bad;
    // R11: reset state
    repeat (4) @(negedge clk);
    check("R11 pull", int'(sclPullLow), 0);
    check("R11 setupDone", int'(setupDone), 0);
    check("R11 strobes", int'(sdaChangeStb | sdaSampleStb), 0);
    rstN = 1'b1;

    // R1 R2 R3 R4 R7 R9 R10: table of timing configurations
    for (int i = 0; i < NVEC; i++) begin
      int fp, hp, perLen, hiLen, loLen, p, sx;
      restart();
      overrideEn = VECS[i].ovr;
      fastMode   = VECS[i].fast;
      cfgPeriod  = VECS[i].fp;
      cfgHigh    = VECS[i].fh;
      cfgSetup   = 8'd2;
      tickDiv    = int'(VECS[i].div);
      fp = VECS[i].ovr ? int'(VECS[i].fp) : (VECS[i].fast ? 21 : 96);
      hp = VECS[i].ovr ? int'(VECS[i].fh) : (VECS[i].fast ? 9 : 47);
      perLen = fp + 4;
      hiLen  = hp + 3;
      loLen  = (perLen > hiLen) ? perLen - hiLen : 1;
      p  = tickDiv;
      sx = (VECS[i].hold > 0) ? int'(VECS[i].hold) - 1 : 0;
      runReq = 1'b1;
      measure(int'(VECS[i].hold), lowC, highC, chgOff, smpOff);
      check($sformatf("R2/R10/R7 low v%0d", i), lowC, loLen * p);
      check($sformatf("R2/R3/R9 high v%0d", i), highC, hiLen * p + sx);
      check($sformatf("R4 change offset v%0d", i), chgOff, (loLen / 2) * p + p - 1);
      check($sformatf("R4 sample offset v%0d", i), smpOff, (hiLen / 2) * p + p - 1 + sx);
      if (VECS[i].ovr && VECS[i].hold == 0 && perLen > hiLen)
        check($sformatf("R1 period v%0d", i), lowC + highC, perLen * p);
    end

    // R6: start from idle waits cfgSetup ticks, then a low phase
    restart();
    overrideEn = 1'b1; cfgPeriod = 8'd20; cfgHigh = 8'd4; cfgSetup = 8'd10;
    tickDiv = 1;
    runReq = 1'b1;
    n = 0;
    @(negedge clk);
    while (!setupDone) begin
      if (sclPullLow) n = 1000;
      n++;
      @(negedge clk);
    end
    check("R6 idle setup ticks", n, 10);
    @(negedge clk);
    check("R6 low after setup", int'(sclPullLow), 1);

    // R5: repeated start, setup longer and shorter than the high phase
    for (int k = 0; k < 2; k++) begin
      cfgSetup = (k == 0) ? 8'd12 : 8'd3;
      while (!sclPullLow) @(negedge clk);
      rptStartReq = 1'b1;
      while (sclPullLow) @(negedge clk);
      n = 0;
      while (!setupDone) begin
        n++;
        @(negedge clk);
      end
      check($sformatf("R5 rise to setupDone k%0d", k), n, (k == 0) ? 12 : 7);
      bad = 0;
      repeat (5) begin
        @(negedge clk);
        if (sclPullLow || !setupDone) bad++;
      end
      check("R5 held released while pending", bad, 0);
      rptStartReq = 1'b0;
      @(negedge clk);
      check("R5 low after request drops", int'(sclPullLow), 1);
    end

    // R8: stop during the high phase and during the low phase
    while (sclPullLow) @(negedge clk);
    runReq = 1'b0;
    bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (sclPullLow || setupDone || sdaChangeStb || sdaSampleStb) bad++;
    end
    check("R8 stopped in high phase", bad, 0);
    runReq = 1'b1;
    while (!sclPullLow) @(negedge clk);
    runReq = 1'b0;
    @(negedge clk);
    check("R8 stop releases from low", int'(sclPullLow), 0);

    // R9: no tick, no progress
    runReq = 1'b1;
    while (!sclPullLow) @(negedge clk);
    tickHalt = 1'b1;
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (!sclPullLow) bad++;
    end
    check("R9 low held without tick", bad, 0);
    tickHalt = 1'b0;

    restart();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule